// File: doc/BRIEF.md
# Network Controller Self-Control Register

This block is the 16-bit self-control register of a network controller. The host reads and writes it through a simple register port. Its fields set the chip's power state and the function of two general-purpose output pins. The low six bits always read as a fixed identifier. One bit asks for a chip-wide reset and clears itself. Another bit places the chip in a software suspend state, and any host I/O write into the device's address window brings the chip out of that state. A further pair of bits lets an active-low sleep input put the chip into a hardware low-power state, and selects which one.

Each of the two output pins either reflects a status signal (link good, or bus receive activity) or is driven by software. Under software control a pin is active low. The block does not itself reset other logic or gate power. It raises a one-cycle chip reset request, a partial reset request that lasts through software suspend, and a two-bit mode code. A load port presets the register in place of a non-volatile preload.

Top module: `pwr_selfctl`

## Requirements
- R1: Synchronous reset puts 0x0015 in the register. Bits 5:0 always read 6'b010101, and writes and loads do not change them.
- R2: Bits 7 and 11 are reserved. They always read 0, and writes and loads do not change them.
- R3: A write with bit 6 set makes bit 6 read 1 and `chip_rst_req` high for exactly one cycle, starting the cycle after the write. On the next cycle the register reads 0x0015, whatever else was written.
- R4: While bit 8 (software suspend) reads 1, the next cycle shows `mode` = 1 (software suspend) and `part_rst_req` = 1. Otherwise `part_rst_req` is 0.
- R5: An `io_wr_hit` pulse clears bit 8 at the next edge. A register write or a load in the same cycle takes precedence over the pulse.
- R6: With bit 9 clear and bit 8 clear, `mode` is 0 (awake) whatever the level of `sleep_n`.
- R7: With bit 9 set and bit 8 clear, `sleep_n` passes through a two-flop synchronizer, and `mode` changes three edges after `sleep_n` changes. A low synchronized level gives `mode` = 2 (hardware standby) when bit 10 is 1, and `mode` = 3 (hardware suspend) when bit 10 is 0. A high level gives 0.
- R8: Software suspend takes priority over the hardware sleep modes. Bit 8 set gives `mode` = 1 whatever bits 9 and 10 and `sleep_n` are.
- R9: `pin0` is registered. When bit 12 is 0 it follows `link_ok`. When bit 12 is 1 it is the inverse of bit 14, so a 1 drives the pin low.
- R10: `pin1` is registered. When bit 13 is 0 it follows `bus_rx_act`. When bit 13 is 1 it is the inverse of bit 15.
- R11: `load_en` writes `load_data` into the writable bits with bit 6 forced to 0. A load takes precedence over `wr_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for this register |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Current register contents |
| io_wr_hit | input | 1 | Any host I/O write inside the device window |
| load_en | input | 1 | Preset strobe |
| load_data | input | 16 | Preset value |
| sleep_n | input | 1 | Asynchronous active-low sleep request |
| link_ok | input | 1 | Link status for pin 0 |
| bus_rx_act | input | 1 | Bus receive activity for pin 1 |
| chip_rst_req | output | 1 | One-cycle chip-wide reset request |
| part_rst_req | output | 1 | Partial reset request during software suspend |
| mode | output | 2 | 0 awake, 1 software suspend, 2 hardware standby, 3 hardware suspend |
| pin0 | output | 1 | General-purpose output pin 0 |
| pin1 | output | 1 | General-purpose output pin 1 |

## Verification
The bench targets the cases where self-clearing and precedence interact. A write that sets bit 6 along with other bits must be discarded a cycle later; a design that kept those bits would leave suspend or pin control stuck. A wake strobe in the same cycle as a write must lose to the write; getting this backwards would drop a freshly written suspend. With bit 8 and bit 9 both set and `sleep_n` low, the bench expects software suspend rather than a hardware mode. Random traffic toggles `sleep_n` against the three-edge synchronizer latency, so a missing or extra stage shows up as a misplaced mode change.

// File: rtl/selfctl_pkg.sv
package selfctl_pkg;
  localparam int REG_W = 16;
  localparam int ID_W  = 6;
  localparam logic [ID_W-1:0] ID_VAL = 6'b010101;

  // bit positions other logic decodes
  localparam int B_RST    = 6;
  localparam int B_SWSUSP = 8;
  localparam int B_SLPEN  = 9;
  localparam int B_STBY   = 10;
  localparam int B_P0EN   = 12;
  localparam int B_P1EN   = 13;
  localparam int B_P0CTL  = 14;
  localparam int B_P1CTL  = 15;

  localparam logic [REG_W-1:0] WR_MASK   = 16'hF740;
  localparam logic [REG_W-1:0] RESET_VAL = {{(REG_W-ID_W){1'b0}}, ID_VAL};

  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    MODE_AWAKE  = 2'd0,
    MODE_SWSUSP = 2'd1,
    MODE_HWSTBY = 2'd2,
    MODE_HWSUSP = 2'd3
  } mode_e;

  function automatic logic [REG_W-1:0] clean_val(input logic [REG_W-1:0] d);
    return (d & WR_MASK) | RESET_VAL;
  endfunction
endpackage

// File: rtl/selfctl_sync.sv
module selfctl_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_LVL;
        else     chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_LVL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/selfctl_regfile.sv
module selfctl_regfile
  import selfctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             load_en,
  input  logic [REG_W-1:0] load_data,
  input  logic             io_wr_hit,
  output logic [REG_W-1:0] reg_q,
  output logic             self_rst
);
  logic [REG_W-1:0] reg_d;
  logic             rst_bit;

  assign rst_bit = reg_q[B_RST];

  always_comb begin
    reg_d = reg_q;
    if (rst_bit) begin
      reg_d = RESET_VAL;
    end else if (load_en) begin
      reg_d = clean_val(load_data);
      reg_d[B_RST] = 1'b0;
    end else if (wr_en) begin
      reg_d = clean_val(wr_data);
    end else if (io_wr_hit) begin
      reg_d[B_SWSUSP] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= RESET_VAL;
    else     reg_q <= reg_d;
  end

  assign self_rst = rst_bit;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    self_rst |=> (!self_rst && reg_q == RESET_VAL)); // R3

  AST_WAKE_ON_IO: assert property (@(posedge clk) disable iff (rst)
    (io_wr_hit && !wr_en && !load_en) |=> !reg_q[B_SWSUSP]); // R5

  AST_LOAD_NO_RST: assert property (@(posedge clk) disable iff (rst)
    (load_en && !self_rst) |=> !self_rst); // R11
endmodule

// File: rtl/selfctl_mode.sv
module selfctl_mode
  import selfctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              susp_i,
  input  logic              sleep_en_i,
  input  logic              stby_sel_i,
  input  logic              sleep_s_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              part_rst_o
);
  mode_e mode_d, mode_q;

  always_comb begin
    if (susp_i)                        mode_d = MODE_SWSUSP;
    else if (sleep_en_i && !sleep_s_i) mode_d = stby_sel_i ? MODE_HWSTBY : MODE_HWSUSP;
    else                               mode_d = MODE_AWAKE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_AWAKE;
      part_rst_o <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      part_rst_o <= susp_i;
    end
  end

  assign mode_o = mode_q;

  AST_SWSUSP_WINS: assert property (@(posedge clk) disable iff (rst)
    susp_i |=> (mode_o == MODE_SWSUSP && part_rst_o)); // R8

  AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!susp_i && !sleep_en_i) |=> (mode_o == MODE_AWAKE && !part_rst_o)); // R6

  AST_HW_MODE: assert property (@(posedge clk) disable iff (rst)
    (!susp_i && sleep_en_i && !sleep_s_i) |=>
      (mode_o == ($past(stby_sel_i) ? MODE_HWSTBY : MODE_HWSUSP))); // R7
endmodule

// File: rtl/selfctl_pins.sv
module selfctl_pins #(
  parameter int NUM_PINS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] sw_en,
  input  logic [NUM_PINS-1:0] sw_lvl_n,
  input  logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] pin_q
);
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst)           pin_q[i] <= 1'b0;
        else if (sw_en[i]) pin_q[i] <= ~sw_lvl_n[i];
        else               pin_q[i] <= status[i];
      end

      AST_PIN_SW: assert property (@(posedge clk) disable iff (rst)
        sw_en[i] |=> (pin_q[i] == !$past(sw_lvl_n[i]))); // R9

      AST_PIN_STATUS: assert property (@(posedge clk) disable iff (rst)
        !sw_en[i] |=> (pin_q[i] == $past(status[i]))); // R10
    end
  endgenerate
endmodule

// File: rtl/pwr_selfctl.sv
module pwr_selfctl
  import selfctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        io_wr_hit,
  input  logic        load_en,
  input  logic [15:0] load_data,
  input  logic        sleep_n,
  input  logic        link_ok,
  input  logic        bus_rx_act,
  output logic        chip_rst_req,
  output logic        part_rst_req,
  output logic [1:0]  mode,
  output logic        pin0,
  output logic        pin1
);
  localparam int NUM_PINS = 2;

  logic [REG_W-1:0]    reg_q;
  logic                self_rst;
  logic                sleep_s;
  logic [NUM_PINS-1:0] pin_en, pin_lvl_n, pin_stat, pin_out;

  selfctl_regfile u_regfile (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .load_en   (load_en),
    .load_data (load_data),
    .io_wr_hit (io_wr_hit),
    .reg_q     (reg_q),
    .self_rst  (self_rst)
  );

  selfctl_sync #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b1)) u_sleep_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sleep_n),
    .q_sync  (sleep_s)
  );

  selfctl_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .susp_i     (reg_q[B_SWSUSP]),
    .sleep_en_i (reg_q[B_SLPEN]),
    .stby_sel_i (reg_q[B_STBY]),
    .sleep_s_i  (sleep_s),
    .mode_o     (mode),
    .part_rst_o (part_rst_req)
  );

  assign pin_en    = {reg_q[B_P1EN],  reg_q[B_P0EN]};
  assign pin_lvl_n = {reg_q[B_P1CTL], reg_q[B_P0CTL]};
  assign pin_stat  = {bus_rx_act, link_ok};

  selfctl_pins #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .sw_en    (pin_en),
    .sw_lvl_n (pin_lvl_n),
    .status   (pin_stat),
    .pin_q    (pin_out)
  );

  assign pin0         = pin_out[0];
  assign pin1         = pin_out[1];
  assign rd_data      = reg_q;
  assign chip_rst_req = self_rst;

  AST_ID_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[5:0] == ID_VAL && !rd_data[7] && !rd_data[11])); // R1 R2
endmodule

// File: tb/pwr_selfctl_bench.sv
module pwr_selfctl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, io_wr_hit = 0, load_en = 0;
  logic [15:0] wr_data = '0, load_data = '0, rd_data;
  logic sleep_n = 1, link_ok = 0, bus_rx_act = 0;
  logic chip_rst_req, part_rst_req, pin0, pin1;
  logic [1:0] mode;

  int checks = 0, errors = 0, seed;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_selfctl u_pwr_selfctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .io_wr_hit(io_wr_hit), .load_en(load_en), .load_data(load_data),
    .sleep_n(sleep_n), .link_ok(link_ok), .bus_rx_act(bus_rx_act),
    .chip_rst_req(chip_rst_req), .part_rst_req(part_rst_req), .mode(mode),
    .pin0(pin0), .pin1(pin1)
  );

  // reference model built from the requirements
  logic [15:0] m_reg;
  logic [1:0]  m_mode;
  logic        m_part, m_p0, m_p1, m_s1, m_s2;

  function automatic logic [15:0] m_clean(input logic [15:0] d);
    return (d & 16'hF740) | 16'h0015;
  endfunction

  function automatic logic [1:0] m_calc_mode(input logic [15:0] r, input logic s);
    if (r[8])              return 2'd1;
    else if (r[9] && !s)   return r[10] ? 2'd2 : 2'd3;
    else                   return 2'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= 16'h0015; m_mode <= 0; m_part <= 0;
      m_p0 <= 0; m_p1 <= 0; m_s1 <= 1; m_s2 <= 1;
    end else begin
      if (m_reg[6])      m_reg <= 16'h0015;
      else if (load_en)  m_reg <= m_clean(load_data) & 16'hFFBF;
      else if (wr_en)    m_reg <= m_clean(wr_data);
      else if (io_wr_hit) m_reg <= m_reg & 16'hFEFF;
      m_s1   <= sleep_n;
      m_s2   <= m_s1;
      m_mode <= m_calc_mode(m_reg, m_s2);
      m_part <= m_reg[8];
      m_p0   <= m_reg[12] ? ~m_reg[14] : link_ok;
      m_p1   <= m_reg[13] ? ~m_reg[15] : bus_rx_act;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 R2 R11 rd_data", rd_data, m_reg);
    chk("R3 chip_rst_req", {15'd0, chip_rst_req}, {15'd0, m_reg[6]});
    chk("R6 R7 R8 mode", {14'd0, mode}, {14'd0, m_mode});
    chk("R4 part_rst_req", {15'd0, part_rst_req}, {15'd0, m_part});
    chk("R9 pin0", {15'd0, pin0}, {15'd0, m_p0});
    chk("R10 pin1", {15'd0, pin1}, {15'd0, m_p1});
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    wr_en = 0; io_wr_hit = 0; load_en = 0;
    check_all();
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 0;
    // R12-style reset state folded into R1 checks
    chk("R1 reset value", rd_data, 16'h0015);
    chk("R4 reset mode", {14'd0, mode}, 16'd0);
    cyc();

    // R1 R2: ID and reserved bits untouched by write
    wr(16'h0000);
    chk("R1 id after zero write", rd_data, 16'h0015);
    wr(16'h08BF & 16'hFFBF);
    chk("R2 reserved bits", rd_data & 16'h0880, 16'h0000);

    // R3: act-once reset discards the rest of the write
    wr(16'hFFFF);
    chk("R3 pulse high", {15'd0, chip_rst_req}, 16'd1);
    cyc();
    chk("R3 back to reset value", rd_data, 16'h0015);
    chk("R3 pulse single", {15'd0, chip_rst_req}, 16'd0);

    // R4 R5: suspend and wake on io write
    wr(16'h0100);
    cyc();
    chk("R4 suspend mode", {14'd0, mode}, 16'd1);
    chk("R4 partial reset", {15'd0, part_rst_req}, 16'd1);
    io_wr_hit = 1; wr_en = 1; wr_data = 16'h0100; cyc();
    chk("R5 write beats wake", rd_data[8], 1'b1);
    io_wr_hit = 1; cyc();
    chk("R5 wake by io write", rd_data[8], 1'b0);
    cyc();

    // R6: sleep ignored when disabled
    sleep_n = 0; wr(16'h0400); cyc(); cyc(); cyc();
    chk("R6 sleep ignored", {14'd0, mode}, 16'd0);
    // R7: standby and hw suspend
    wr(16'h0600); cyc();
    chk("R7 hw standby", {14'd0, mode}, 16'd2);
    wr(16'h0200); cyc();
    chk("R7 hw suspend", {14'd0, mode}, 16'd3);
    sleep_n = 1; cyc(); cyc(); cyc();
    chk("R7 awake on sleep high", {14'd0, mode}, 16'd0);
    // R8: software suspend wins
    sleep_n = 0; wr(16'h0700); cyc(); cyc(); cyc();
    chk("R8 swsusp priority", {14'd0, mode}, 16'd1);
    sleep_n = 1;

    // R9 R10: pins
    link_ok = 1; bus_rx_act = 0; wr(16'h0000); cyc();
    chk("R9 pin0 status", {15'd0, pin0}, 16'd1);
    wr(16'h7000); cyc();
    chk("R9 pin0 sw low", {15'd0, pin0}, 16'd0);
    chk("R10 pin1 sw high", {15'd0, pin1}, 16'd1);
    wr(16'hB000); cyc();
    chk("R10 pin1 sw low", {15'd0, pin1}, 16'd0);
    chk("R9 pin0 sw high", {15'd0, pin0}, 16'd1);

    // R11: load beats write and never sets bit 6
    load_en = 1; load_data = 16'hFFFF; wr_en = 1; wr_data = 16'h0000; cyc();
    chk("R11 load value", rd_data, 16'hF715);
    chk("R11 no reset from load", {15'd0, chip_rst_req}, 16'd0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      wr_en      = ($urandom % 4) == 0;
      wr_data    = $urandom;
      if (($urandom % 16) != 0) wr_data[6] = 1'b0;
      io_wr_hit  = ($urandom % 4) == 0;
      load_en    = ($urandom % 32) == 0;
      load_data  = $urandom;
      link_ok    = $urandom;
      bus_rx_act = $urandom;
      if (($urandom % 8) == 0) sleep_n = ~sleep_n;
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule